// File: doc/BRIEF.md
# Power-Up Instruction Gating Controller

This block sits between the opcode decoder of a serial flash memory and the rest of its command logic. It decides, from the state of the supply, whether each decoded instruction may run. Two supply-monitor comparator outputs come in without a clock relationship. One says the supply is above the write-inhibit threshold. The other says it is above the minimum operating level. A strobe with a 3-bit instruction class arrives from the serial front end for each decoded instruction.

Each comparator input passes through a two-flop synchronizer. While the write-inhibit comparator is low, the block holds the internal reset and refuses every instruction. Once that comparator is high, a write-access counter starts. Write-class instructions stay blocked until that counter finishes. A second counter starts when both comparators are high. It enables read-class instructions, which may become allowed well before write-class ones. On leaving reset the block sends a one-cycle pulse that clears the write enable latch. Every strobed instruction is answered one cycle later with either an accept pulse or a drop pulse.

Top module: `pwrup_gate`

## Requirements
- R1: `por_rst` reflects the inverse of `wi_raw` delayed by exactly two clock edges (two-flop synchronizer); while it is high, `rd_ok` and `wr_ok` are low.
- R2: `wr_ok` goes high WR_DLY+2 clock edges after `wi_raw` is first sampled high, provided `wi_raw` stays high throughout, and stays high while `wi_raw` remains high.
- R3: `rd_ok` goes high RD_DLY+2 edges after `wi_raw` and `min_raw` are both sampled high, provided both stay high throughout, independently of `wr_ok`.
- R4: If a comparator input falls before its delay completes, the matching counter restarts from zero, and the full delay is required again after the input returns high.
- R5: `wel_clr` is a single-cycle pulse, high in the cycle in which `por_rst` first goes low after being high.
- R6: Class codes 1 to 5 (write enable, page program, sector erase, bulk erase, write status) are write-class and are accepted only if `wr_ok` was high in the cycle of the strobe.
- R7: Class codes 0, 6 and 7 (read, status read, any other) are read-class and are accepted only if `rd_ok` was high in the cycle of the strobe.
- R8: Each strobe (`cmd_valid` high) produces exactly one of `cmd_acc` or `cmd_drop`, one cycle after the strobe; neither pulses without a strobe.
- R9: While `rst_n` is low, `por_rst` is high and `rd_ok`, `wr_ok`, `wel_clr`, `cmd_acc` and `cmd_drop` are low.
- R10: After `wi_raw` falls, `rd_ok` and `wr_ok` drop, and all instructions are refused, two edges later, matching `por_rst` rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low system reset |
| wi_raw | input | 1 | Asynchronous comparator: supply above write-inhibit threshold |
| min_raw | input | 1 | Asynchronous comparator: supply above minimum operating level |
| cmd_valid | input | 1 | One-cycle strobe for a decoded instruction |
| cmd_kind | input | 3 | Instruction class code (see R6, R7) |
| por_rst | output | 1 | Internal reset for the command logic |
| rd_ok | output | 1 | Read-class instructions permitted |
| wr_ok | output | 1 | Write-class instructions permitted |
| wel_clr | output | 1 | One-cycle clear of the write enable latch |
| cmd_acc | output | 1 | Instruction accepted, one cycle after its strobe |
| cmd_drop | output | 1 | Instruction dropped, one cycle after its strobe |

## Verification
A counter that runs off by one cycle moves the rise of `rd_ok` or `wr_ok` away from its expected edge. The bench compares every cycle, so it reports the error at that exact edge. A counter that fails to restart after a brief supply glitch grants access too early after the glitch. The first strobe in that window then gives `cmd_acc` where `cmd_drop` was expected, one cycle after the strobe. A wrong class decode appears on the very next strobe of the misclassified code whenever read and write permissions differ. Missing synchronizer stages shift `por_rst` and `wel_clr` by a whole cycle.

// File: rtl/pwrup_gate.sv
module pwrup_gate #(
  parameter int RD_DLY = 64,
  parameter int WR_DLY = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wi_raw,
  input  logic       min_raw,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_kind,
  output logic       por_rst,
  output logic       rd_ok,
  output logic       wr_ok,
  output logic       wel_clr,
  output logic       cmd_acc,
  output logic       cmd_drop
);

  localparam int RW = $clog2(RD_DLY + 1);
  localparam int WW = $clog2(WR_DLY + 1);
  localparam logic [RW-1:0] RD_END = RW'(RD_DLY);
  localparam logic [WW-1:0] WR_END = WW'(WR_DLY);

  logic [1:0]    wi_sy, mn_sy;
  logic          wi_prev;
  logic [RW-1:0] rcnt;
  logic [WW-1:0] wcnt;

  wire wi_on  = wi_sy[1];
  wire rd_qual = wi_sy[1] & mn_sy[1];
  wire is_wr  = (cmd_kind >= 3'd1) && (cmd_kind <= 3'd5);
  wire allow  = is_wr ? wr_ok : rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wi_sy   <= '0;
      mn_sy   <= '0;
      wi_prev <= 1'b0;
    end else begin
      wi_sy   <= {wi_sy[0], wi_raw};
      mn_sy   <= {mn_sy[0], min_raw};
      wi_prev <= wi_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wcnt <= '0;
    else if (!wi_on)       wcnt <= '0;
    else if (wcnt != WR_END) wcnt <= wcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rcnt <= '0;
    else if (!rd_qual)     rcnt <= '0;
    else if (rcnt != RD_END) rcnt <= rcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_acc  <= 1'b0;
      cmd_drop <= 1'b0;
    end else begin
      cmd_acc  <= cmd_valid & allow;
      cmd_drop <= cmd_valid & ~allow;
    end
  end

  assign por_rst = ~wi_on;
  assign wr_ok   = wi_on & (wcnt == WR_END);
  assign rd_ok   = rd_qual & (rcnt == RD_END);
  assign wel_clr = wi_on & ~wi_prev;

endmodule

module pwrup_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_kind,
  input logic       por_rst,
  input logic       rd_ok,
  input logic       wr_ok,
  input logic       wel_clr,
  input logic       cmd_acc,
  input logic       cmd_drop
);

  AST_POR_BLOCKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n) por_rst |-> (!rd_ok && !wr_ok)); // R1
  AST_POR_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) por_rst |=> !cmd_acc); // R10
  AST_WEL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wel_clr |=> !wel_clr); // R5
  AST_WEL_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n) wel_clr |-> (!por_rst && $past(por_rst))); // R5
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> $countones({cmd_acc, cmd_drop}) == 1); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !cmd_valid |=> !(cmd_acc || cmd_drop)); // R8
  AST_WR_GATE: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_kind >= 3'd1 && cmd_kind <= 3'd5 && !wr_ok) |=> cmd_drop); // R6
  AST_RD_GATE: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && (cmd_kind == 3'd0 || cmd_kind >= 3'd6) && !rd_ok) |=> cmd_drop); // R7

endmodule

bind pwrup_gate pwrup_gate_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .por_rst(por_rst), .rd_ok(rd_ok), .wr_ok(wr_ok), .wel_clr(wel_clr),
  .cmd_acc(cmd_acc), .cmd_drop(cmd_drop)
);

// File: tb/test_pwrup_gate.sv
module test_pwrup_gate;
  localparam int RD = 6;
  localparam int WR = 20;

  logic clk = 0, rst_n = 0, wi_raw = 0, min_raw = 0, cmd_valid = 0;
  logic [2:0] cmd_kind = 0;
  logic por_rst, rd_ok, wr_ok, wel_clr, cmd_acc, cmd_drop;

  int n_run = 0, n_fail = 0;
  int wrun = 0, brun = 0;
  logic e_por = 1, e_rd = 0, e_wr = 0, e_wel = 0, e_acc = 0, e_drop = 0;

  always #10 clk = ~clk;

  pwrup_gate #(.RD_DLY(RD), .WR_DLY(WR)) i_pwrup_gate (
    .clk, .rst_n, .wi_raw, .min_raw, .cmd_valid, .cmd_kind,
    .por_rst, .rd_ok, .wr_ok, .wel_clr, .cmd_acc, .cmd_drop);

  function automatic bit wr_class(input logic [2:0] k);
    return (k >= 3'd1) && (k <= 3'd5);
  endfunction

  task automatic chk(input string r, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", r, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic wi, input logic mn, input logic v, input logic [2:0] k);
    int pw, pb;
    wi_raw = wi; min_raw = mn; cmd_valid = v; cmd_kind = k;
    @(posedge clk);
    e_acc  = v && (wr_class(k) ? e_wr : e_rd);
    e_drop = v && !(wr_class(k) ? e_wr : e_rd);
    pw = wrun; pb = brun;
    wrun = wi ? (wrun < 1000 ? wrun + 1 : wrun) : 0;
    brun = (wi && mn) ? (brun < 1000 ? brun + 1 : brun) : 0;
    e_por = (pw == 0);
    e_wel = (pw == 1);
    e_wr  = (pw >= WR + 1);
    e_rd  = (pb >= RD + 1);
    #5;
    chk("R1 por_rst", por_rst, e_por);
    chk("R2/R4/R10 wr_ok", wr_ok, e_wr);
    chk("R3/R4/R10 rd_ok", rd_ok, e_rd);
    chk("R5 wel_clr", wel_clr, e_wel);
    chk(v && wr_class(k) ? "R6 cmd_acc" : "R7 cmd_acc", cmd_acc, e_acc);
    chk("R8 cmd_drop", cmd_drop, e_drop);
    @(negedge clk);
  endtask

  initial begin
    #200000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 por_rst", por_rst, 1'b1);
    chk("R9 rd_ok", rd_ok, 1'b0);
    chk("R9 wr_ok", wr_ok, 1'b0);
    chk("R9 wel_clr", wel_clr, 1'b0);
    chk("R9 cmd_acc", cmd_acc, 1'b0);
    chk("R9 cmd_drop", cmd_drop, 1'b0);
    rst_n = 1;
    @(negedge clk);
    // Directed: write-inhibit up, minimum later; reads open before writes (R3)
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 3'(i));
    for (int i = 0; i < 30; i++) cyc(1, 1, 1, 3'(i % 8));
    // Directed: glitch on wi before write delay completes (R4)
    for (int i = 0; i < 10; i++) cyc(1, 1, 1, 3'd2);
    cyc(0, 1, 1, 3'd6);
    for (int i = 0; i < WR + 6; i++) cyc(1, 1, 1, 3'(i % 8));
    // Directed: glitch on min only; writes stay, reads restart (R4)
    cyc(1, 0, 1, 3'd0);
    for (int i = 0; i < RD + 4; i++) cyc(1, 1, 1, (i % 2) ? 3'd0 : 3'd4);
    // Directed: power-down (R10)
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 3'(i + 1));
    // Random phases
    for (int p = 0; p < 120; p++) begin
      logic wi, mn;
      int len;
      wi  = ($urandom % 5) != 0;
      mn  = ($urandom % 4) != 0;
      len = ($urandom % 2) ? 1 + ($urandom % 4) : 5 + ($urandom % 40);
      for (int i = 0; i < len; i++)
        cyc(wi, mn, ($urandom % 3) != 0, 3'($urandom % 8));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule